// File: doc/BRIEF.md
# Serial Port FIFO and Status Flags

This block sits between a host bus and the shift logic of a frame-based serial port. The host writes words into a transmit queue and takes words out of a receive queue. The serial side pulls one transmit word at each slot load strobe and pushes each received word with its own strobe. Neither the shifter nor the slot clocking is part of the block; they appear here only as single-cycle strobes.

A four-bit status word collects the error and request conditions. Three error bits are sticky and are cleared by writing 1 to them. They are transmit overrun (bit 0), transmit underrun (bit 1) and frame sync error (bit 2). Bit 3 is a level that shows whether the receive queue holds more words than a programmable watermark. A four-bit enable mask, with the same bit order, gates these bits onto a transmit interrupt (bits 0 to 2) and a receive interrupt (bit 3).

A small frame tracker has three states. FR_IDLE means no frame has started since enabling. FR_BUSY means a frame is running and slots are being counted. FR_DONE means every slot of the frame has ended. The transitions are:
- start: FR_IDLE to FR_BUSY on a frame sync.
- complete: FR_BUSY to FR_DONE when the last slot ends.
- early sync: FR_BUSY to FR_BUSY on a frame sync. This raises the error and restarts the slot count.
- next: FR_DONE to FR_BUSY on a frame sync.
- halt: any state to FR_IDLE while both enables are low.

Top module: `sport_fifo_flags`

## Requirements
- R1: After reset all four status bits are 0, both interrupts are 0, both queues are empty and the transmitted word output is 0.
- R2: Words written by the host with the transmit enable set leave on `ser_tx_data` in the order written. Each word is visible from the clock edge of its slot load. The transmit queue holds 16 words.
- R3: A host write while the transmit queue holds 16 words sets status bit 0 and discards the written word.
- R4: A slot load while the transmit queue is empty sets status bit 1 and leaves `ser_tx_data` at the previously sent word. That word is 0 if nothing has been sent since reset.
- R5: Received words are read back in arrival order from `host_rd_data`, which shows the oldest word; `host_rd` removes it. A push into a full receive queue (16 words) is dropped.
- R6: Status bit 3 is 1 exactly when the receive queue count is greater than `rx_watermark`.
- R7: A frame sync that arrives while the current frame has seen fewer than `SLOTS` slot ends sets status bit 2. A frame sync after a complete frame does not set it. Slot counting restarts at every frame sync.
- R8: A status write clears each of bits 0 to 2 whose written bit is 1 and leaves the other bits unchanged. Writes have no effect on bit 3.
- R9: When a setting event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: Overrun and underrun are only recorded while `tx_en` is 1, and frame sync errors only while `tx_en` or `rx_en` is 1. A low `tx_en` empties the transmit queue, and a low `rx_en` empties the receive queue.
- R11: `tx_irq` is 1 when any of status bits 0 to 2 is 1 with its `irq_en` bit set. `rx_irq` is 1 when status bit 3 and `irq_en[3]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable; low flushes the transmit queue |
| rx_en | input | 1 | Receive enable; low flushes the receive queue |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wr_data | input | WIDTH | Host transmit word |
| host_rd | input | 1 | Host read strobe, removes the oldest received word |
| host_rd_data | output | WIDTH | Oldest received word |
| ser_load | input | 1 | Slot load strobe from the serial side |
| ser_tx_data | output | WIDTH | Word sent at the latest slot load |
| ser_push | input | 1 | Received word strobe from the serial side |
| ser_rx_data | input | WIDTH | Received word |
| fsync | input | 1 | Frame sync strobe |
| slot_end | input | 1 | End-of-slot strobe |
| rx_watermark | input | CW | Receive request threshold |
| st_clr_wr | input | 1 | Status clear write strobe |
| st_clr_data | input | 4 | Clear mask, 1 clears the bit |
| irq_en | input | 4 | Interrupt enable per status bit |
| status | output | 4 | {receive request, frame sync error, underrun, overrun} |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Wrong internal state in this block shows up at different times depending on where it is:
- A bad queue pointer or count appears at `ser_tx_data` on the next slot load, or at `host_rd_data` as soon as the head moves. A miscount near the full or empty edge appears one edge later as a wrong overrun or underrun bit, or a premature one.
- A sticky bit that fails to hold or to clear is visible in `status` and the interrupts one cycle after the event.
- A frame tracker stuck in the wrong state stays hidden until the next frame sync, so the sync tests arrive both before and after the last slot end.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int FLAG_OVR = 0;
    localparam int FLAG_UDR = 1;
    localparam int FLAG_FSE = 2;
    localparam int FLAG_RRQ = 3;
    localparam int N_ERR    = 3;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_BUSY = 2'd1,
        FR_DONE = 2'd2
    } frame_state_e;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R2: occupancy never passes the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: a push into a full queue without a pop leaves it full
    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !flush |=> count == CW'(DEPTH));
endmodule

// File: rtl/sport_frame_fsm.sv
module sport_frame_fsm
    import sport_pkg::*;
#(
    parameter int SLOTS = 2,
    localparam int SW   = $clog2(SLOTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fsync,
    input  logic slot_end,
    output logic fse_evt
);
    frame_state_e state, state_nx;
    logic [SW-1:0] slots, slots_nx;
    logic          last_slot;

    assign last_slot = slot_end && (slots == SW'(SLOTS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            slots <= '0;
        end else begin
            state <= state_nx;
            slots <= slots_nx;
        end
    end

    always_comb begin
        state_nx = state;
        slots_nx = slots;
        if (!active) begin
            state_nx = FR_IDLE;
            slots_nx = '0;
        end else begin
            unique case (state)
                FR_IDLE: if (fsync) begin
                    state_nx = FR_BUSY;
                    slots_nx = '0;
                end
                FR_BUSY: if (fsync) begin
                    state_nx = FR_BUSY;
                    slots_nx = '0;
                end else if (last_slot) begin
                    state_nx = FR_DONE;
                    slots_nx = '0;
                end else if (slot_end) begin
                    slots_nx = slots + 1'b1;
                end
                FR_DONE: if (fsync) begin
                    state_nx = FR_BUSY;
                    slots_nx = '0;
                end
                default: begin
                    state_nx = FR_IDLE;
                    slots_nx = '0;
                end
            endcase
        end
    end

    always_comb begin
        fse_evt = 1'b0;
        unique case (state)
            FR_BUSY: fse_evt = active && fsync && !last_slot;
            default: fse_evt = 1'b0;
        endcase
    end

    // R7: a sync out of idle always opens a frame
    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        active && fsync && state == FR_IDLE |=> state == FR_BUSY);

    // R10: without any enable the tracker returns to idle
    a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> state == FR_IDLE);
endmodule

// File: rtl/sport_flags.sv
module sport_flags
    import sport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_evt,
    input  logic       udr_evt,
    input  logic       fse_evt,
    input  logic       rx_req,
    input  logic       clr_wr,
    input  logic [3:0] clr_data,
    input  logic [3:0] irq_en,
    output logic [3:0] status,
    output logic       tx_irq,
    output logic       rx_irq
);
    logic [N_ERR-1:0] err_q, set_v, clr_v;

    always_comb begin
        set_v           = '0;
        set_v[FLAG_OVR] = ovr_evt;
        set_v[FLAG_UDR] = udr_evt;
        set_v[FLAG_FSE] = fse_evt;
        clr_v           = clr_wr ? clr_data[N_ERR-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_v) | set_v;
    end

    always_comb begin
        status           = '0;
        status[N_ERR-1:0] = err_q;
        status[FLAG_RRQ] = rx_req;
        tx_irq           = |(err_q & irq_en[N_ERR-1:0]);
        rx_irq           = rx_req && irq_en[FLAG_RRQ];
    end

    // R9: an overrun event lands even against a clearing write
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> status[FLAG_OVR]);

    // R8: write-1 clears when no event competes
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && clr_data[FLAG_UDR] && !udr_evt |=> !status[FLAG_UDR]);

    // R8: a set bit is held unless it is cleared
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        status[FLAG_FSE] && !(clr_wr && clr_data[FLAG_FSE]) |=> status[FLAG_FSE]);
endmodule

// File: rtl/sport_fifo_flags.sv
module sport_fifo_flags
    import sport_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int SLOTS = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wr_data,
    input  logic             host_rd,
    output logic [WIDTH-1:0] host_rd_data,
    input  logic             ser_load,
    output logic [WIDTH-1:0] ser_tx_data,
    input  logic             ser_push,
    input  logic [WIDTH-1:0] ser_rx_data,
    input  logic             fsync,
    input  logic             slot_end,
    input  logic [CW-1:0]    rx_watermark,
    input  logic             st_clr_wr,
    input  logic [3:0]       st_clr_data,
    input  logic [3:0]       irq_en,
    output logic [3:0]       status,
    output logic             tx_irq,
    output logic             rx_irq
);
    logic [WIDTH-1:0] tx_head, last_sent;
    logic [CW-1:0]    tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_pop, ovr_evt, udr_evt, fse_evt, rx_req;

    assign tx_pop  = ser_load && tx_en && !tx_empty;
    assign ovr_evt = host_wr && tx_en && tx_full;
    assign udr_evt = ser_load && tx_en && tx_empty;
    assign rx_req  = rx_count > rx_watermark;

    sport_fifo #(.W(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!tx_en),
        .push  (host_wr),
        .din   (host_wr_data),
        .pop   (tx_pop),
        .head  (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sport_fifo #(.W(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!rx_en),
        .push  (ser_push),
        .din   (ser_rx_data),
        .pop   (host_rd),
        .head  (host_rd_data),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_sent <= '0;
        else if (tx_pop) last_sent <= tx_head;
    end
    assign ser_tx_data = last_sent;

    sport_frame_fsm #(.SLOTS(SLOTS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (tx_en || rx_en),
        .fsync    (fsync),
        .slot_end (slot_end),
        .fse_evt  (fse_evt)
    );

    sport_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_evt  (ovr_evt),
        .udr_evt  (udr_evt),
        .fse_evt  (fse_evt),
        .rx_req   (rx_req),
        .clr_wr   (st_clr_wr),
        .clr_data (st_clr_data),
        .irq_en   (irq_en),
        .status   (status),
        .tx_irq   (tx_irq),
        .rx_irq   (rx_irq)
    );

    // R4: an underrun resends the word already on the line
    a_r4_resend: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load && tx_en && tx_empty |=> $stable(ser_tx_data));

    // R3: an overrun write leaves the queue exactly full
    a_r3_discard: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && tx_en && tx_full && !ser_load |=> tx_count == CW'(DEPTH));

    // R10: a disabled transmit side holds an empty queue
    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tx_empty);

    // R10: with both sides disabled no error bit moves except by clearing
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en && !rx_en && !st_clr_wr |=> $stable(status[2:0]));

    // R5: the receive queue never reports full and empty together
    a_r5_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));
endmodule

// File: tb/sport_fifo_flags_test.sv
module sport_fifo_flags_test;
    localparam int W  = 32;
    localparam int D  = 16;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 0, rx_en = 0, host_wr = 0, host_rd = 0;
    logic [W-1:0]  host_wr_data = '0, ser_rx_data = '0;
    logic          ser_load = 0, ser_push = 0, fsync = 0, slot_end = 0;
    logic [CW-1:0] rx_watermark = '0;
    logic          st_clr_wr = 0;
    logic [3:0]    st_clr_data = '0, irq_en = '0;
    logic [W-1:0]  host_rd_data, ser_tx_data;
    logic [3:0]    status;
    logic          tx_irq, rx_irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    sport_fifo_flags #(.WIDTH(W), .DEPTH(D), .SLOTS(2)) uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .host_wr(host_wr), .host_wr_data(host_wr_data),
        .host_rd(host_rd), .host_rd_data(host_rd_data),
        .ser_load(ser_load), .ser_tx_data(ser_tx_data),
        .ser_push(ser_push), .ser_rx_data(ser_rx_data),
        .fsync(fsync), .slot_end(slot_end), .rx_watermark(rx_watermark),
        .st_clr_wr(st_clr_wr), .st_clr_data(st_clr_data), .irq_en(irq_en),
        .status(status), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [W-1:0] d);
        host_wr = 1; host_wr_data = d; tick(); host_wr = 0;
    endtask
    task automatic load();
        ser_load = 1; tick(); ser_load = 0;
    endtask
    task automatic push(input logic [W-1:0] d);
        ser_push = 1; ser_rx_data = d; tick(); ser_push = 0;
    endtask
    task automatic rd();
        host_rd = 1; tick(); host_rd = 0;
    endtask
    task automatic clr(input logic [3:0] m);
        st_clr_wr = 1; st_clr_data = m; tick(); st_clr_wr = 0; st_clr_data = '0;
    endtask
    task automatic fs();
        fsync = 1; tick(); fsync = 0;
    endtask
    task automatic se();
        slot_end = 1; tick(); slot_end = 0;
    endtask
    task automatic tx_flush();
        tx_en = 0; tick(); tx_en = 1; tick();
    endtask

    task automatic t_reset();
        chk("R1 status", W'(status), '0);
        chk("R1 ser_tx_data", ser_tx_data, '0);
        chk("R1 irqs", W'({tx_irq, rx_irq}), '0);
        rx_en = 1; rx_watermark = '0; #1;
        chk("R1 rx queue empty", W'(status[3]), '0);
        rx_en = 0; tick();
    endtask

    task automatic t_first_underrun();
        tx_en = 1; tick();
        load();
        chk("R4 zero before any send", ser_tx_data, '0);
        chk("R4 underrun bit", W'(status), 32'h2);
        clr(4'b0010);
        chk("R8 underrun cleared", W'(status), '0);
    endtask

    task automatic t_tx_order();
        wr(32'hA1); wr(32'hB2); wr(32'hC3);
        load(); chk("R2 first word", ser_tx_data, 32'hA1);
        load(); chk("R2 second word", ser_tx_data, 32'hB2);
        load(); chk("R2 third word", ser_tx_data, 32'hC3);
        chk("R2 no error", W'(status), '0);
        load();
        chk("R4 resend last", ser_tx_data, 32'hC3);
        chk("R4 underrun set", W'(status[1]), 1);
        clr(4'b0010);
    endtask

    task automatic t_overrun_and_w1c();
        for (int i = 0; i < D; i++) wr(32'h100 + W'(i));
        chk("R3 full, no overrun yet", W'(status[0]), 0);
        wr(32'h1FF);
        chk("R3 overrun bit", W'(status[0]), 1);
        // R9: same-cycle overrun and clear keeps the bit
        host_wr = 1; host_wr_data = 32'h2FF; st_clr_wr = 1; st_clr_data = 4'b0001;
        tick();
        host_wr = 0; st_clr_wr = 0; st_clr_data = '0;
        chk("R9 set wins", W'(status[0]), 1);
        // R11 interrupt gating
        irq_en = 4'b0000; #1; chk("R11 masked", W'(tx_irq), 0);
        irq_en = 4'b0001; #1; chk("R11 overrun irq", W'(tx_irq), 1);
        irq_en = 4'b0110; #1; chk("R11 other enables", W'(tx_irq), 0);
        irq_en = '0;
        for (int i = 0; i < D; i++) load();
        chk("R3 sixteenth word kept", ser_tx_data, 32'h10F);
        load();
        chk("R3 extra words discarded", ser_tx_data, 32'h10F);
        chk("R4 underrun after drain", W'(status[1:0]), 32'h3);
        clr(4'b0000);
        chk("R8 zero write keeps", W'(status), 32'h3);
        clr(4'b0001);
        chk("R8 clear bit 0 only", W'(status), 32'h2);
        clr(4'b1110);
        chk("R8 clear rest", W'(status), '0);
    endtask

    task automatic t_rx();
        rx_en = 1; rx_watermark = CW'(2); tick();
        push(32'h11); push(32'h22);
        chk("R6 count 2 not above 2", W'(status[3]), 0);
        push(32'h33);
        chk("R6 count 3 above 2", W'(status[3]), 1);
        irq_en = 4'b1000; #1; chk("R11 rx irq", W'(rx_irq), 1);
        irq_en = 4'b0000; #1; chk("R11 rx irq masked", W'(rx_irq), 0);
        clr(4'b1000);
        chk("R8 write ignores bit 3", W'(status[3]), 1);
        chk("R5 head oldest", host_rd_data, 32'h11);
        rd();
        chk("R6 falls at 2", W'(status[3]), 0);
        chk("R5 second", host_rd_data, 32'h22); rd();
        chk("R5 third", host_rd_data, 32'h33); rd();
        rx_watermark = '0; #1;
        chk("R6 empty", W'(status[3]), 0);
        for (int i = 0; i <= D; i++) push(32'h200 + W'(i));
        for (int i = 0; i < D; i++) begin
            chk("R5 full order", host_rd_data, 32'h200 + W'(i));
            rd();
        end
        chk("R5 overflow push dropped", W'(status[3]), 0);
    endtask

    task automatic t_fsync();
        tx_en = 1; rx_en = 1; tick();
        fs(); se(); se();
        fs();
        chk("R7 complete frame no error", W'(status[2]), 0);
        se();
        fs();
        chk("R7 early sync error", W'(status[2]), 1);
        clr(4'b0100);
        se(); se(); fs();
        chk("R7 count restarted", W'(status[2]), 0);
        irq_en = 4'b0100;
        se(); fs();
        chk("R11 fse irq", W'(tx_irq), 1);
        irq_en = '0;
        clr(4'b0100);
    endtask

    task automatic t_enables();
        tx_en = 0; rx_en = 0; tick();
        wr(32'hDEAD);
        load();
        chk("R10 no tx errors when disabled", W'(status), '0);
        chk("R10 line unchanged when disabled", ser_tx_data, 32'h10F);
        fs(); fs();
        chk("R10 no fse when disabled", W'(status), '0);
        rx_en = 1; tick();
        fs(); fs();
        chk("R10 fse with rx only", W'(status[2]), 1);
        clr(4'b0100);
        tx_en = 1; tick();
        wr(32'h55); wr(32'h66);
        tx_flush();
        load();
        chk("R10 tx flushed", W'(status[1]), 1);
        chk("R10 flushed word not sent", ser_tx_data, 32'h10F);
        clr(4'b0010);
        push(32'h77); push(32'h88);
        rx_en = 0; tick(); rx_en = 1; tick();
        rx_watermark = '0; #1;
        chk("R10 rx flushed", W'(status[3]), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_first_underrun();
        t_tx_order();
        t_overrun_and_w1c();
        t_rx();
        t_fsync();
        t_enables();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule